// File: doc/BRIEF.md
# Prefix Instruction Combiner

This is a pipeline stage that sits in front of the instruction decoder. Each cycle it takes a fetch group of up to `LANES` 32-bit words. Any word in the group may be a base instruction or a prefix word. A base instruction has three 5-bit register fields. A prefix word carries the upper three bits of each of those fields for the one or two base instructions just before it. The stage joins each prefix's extension bits to its targets and builds widened 8-bit register numbers. It then drops the consumed prefixes and packs the remaining entries into a registered output vector for the decoder. An 8-bit number reaches a 256-entry floating-point register file. Integer decode uses only the lowest extension bit, which gives a sixth bit for the 32 extra integer registers that sit outside the windowed set.

A prefix can arrive in the fetch group after its target. To allow for this, the last base instruction of every group is held back for one cycle. In the next cycle it is placed ahead of the new group's words. If a prefix then starts the new group, it merges into the held instruction. A prefix with no valid target is not dropped: it is passed on in its own output slot with an illegal-instruction flag set.

Valid input lanes must be contiguous from lane 0. The output has `LANES+1` slots. Valid slots are contiguous from slot 0, and at most `LANES` of them carry base instructions.

Top module: `pfx_combiner`

## Requirements
- R1: A word whose bits [31:24] equal 0xF7 is a prefix. Bit 23 set means the prefix serves two bases. Bits [8:0] extend the base immediately before the prefix. Bits [17:9] extend the base before that one and are used only when bit 23 is set.
- R2: Each 9-bit extension splits as [2:0] for the destination, [5:3] for source 1 and [8:6] for source 2. The widened fields are {ext[2:0], word[29:25]}, {ext[5:3], word[18:14]} and {ext[8:6], word[4:0]}.
- R3: A base instruction that no prefix extends gets all-zero extension bits.
- R4: A prefix that matches its target or targets does not appear at the output.
- R5: A prefix is unmatched when the entry just before it is not a base, or when its pair bit is set and the entry two before it is not a base. An unmatched prefix takes an output slot with the illegal flag set and the prefix word on the word output.
- R6: The last base instruction of a group is held for one cycle and then emitted in slot 0. It takes its extension from a matching prefix in the next group, either a single prefix at lane 0 or a pair prefix at lane 1.
- R7: A held instruction is emitted in the next cycle even when that cycle brings no valid input.
- R8: Emitted entries keep stream order (held entry first, then lanes ascending) and fill slots contiguously from slot 0.
- R9: Outputs are registered. A group's results appear after the next rising clock edge. Reset clears all output valids and any held instruction.
- R10: At most `LANES` output slots carry base instructions in any cycle. The one extra slot can only be filled when unmatched prefixes are present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | LANES | Per-lane valid for the fetch group, contiguous from lane 0 |
| inWord | input | LANES*32 | Fetch group words, lane j at bits [32j+31:32j] |
| outValid | output | LANES+1 | Per-slot valid, contiguous from slot 0 |
| outIllegal | output | LANES+1 | Slot holds an unmatched prefix |
| outWord | output | (LANES+1)*32 | Original word per slot |
| outRd | output | (LANES+1)*8 | Widened destination register number per slot |
| outRs1 | output | (LANES+1)*8 | Widened source 1 register number per slot |
| outRs2 | output | (LANES+1)*8 | Widened source 2 register number per slot |

## Verification
The input groups cover several cases. A group of bases only shows that unextended bases get zero extension bits and that the last base is held. A prefix in the middle of a group and a prefix at the end of a group show whether the extension goes to the nearest base, and that nothing is held when the group ends in a prefix. Pair prefixes check that the near field and the far field land on the correct bases. This is done both inside one group and across a group boundary against the held instruction, which shows whether the held entry really takes part in matching. Orphan, back-to-back and half-matched prefixes, plus one held base followed by four unmatched prefixes, check the illegal path and the extra fifth output slot.

// File: rtl/pfx_comb_pkg.sv
package pfx_comb_pkg;
  localparam int WORD_W   = 32;
  localparam int REG_W    = 5;
  localparam int EXT_W    = 3;
  localparam int WIDE_W   = REG_W + EXT_W;
  localparam int PEXT_W   = 3 * EXT_W;
  localparam logic [7:0] PFX_TAG = 8'hF7;
  localparam int TAG_LSB  = 24;
  localparam int PAIR_BIT = 23;
  localparam int FAR_LSB  = PEXT_W;
  localparam int RD_LSB   = 25;
  localparam int RS1_LSB  = 14;
  localparam int RS2_LSB  = 0;

  // classification of one stream entry (held entry or input lane)
  typedef struct packed {
    logic valid;
    logic isPfx;
    logic pair;
  } entryCls_t;

  // strobes from control to datapath for one stream entry
  typedef struct packed {
    logic emit;
    logic illegal;
    logic extNear;
    logic extFar;
    logic trail;
  } entryCtl_t;

  typedef struct packed {
    logic              valid;
    logic              illegal;
    logic [WORD_W-1:0] word;
    logic [WIDE_W-1:0] rd;
    logic [WIDE_W-1:0] rs1;
    logic [WIDE_W-1:0] rs2;
  } slot_t;

  function automatic logic [WIDE_W-1:0] widen(input logic [REG_W-1:0] f,
                                               input logic [EXT_W-1:0] e);
    return {e, f};
  endfunction
endpackage

// File: rtl/pfx_comb_ctl.sv
module pfx_comb_ctl
  import pfx_comb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  entryCls_t cls [LANES+1],
  output entryCtl_t ctl [LANES+1]
);
  localparam int SEQ = LANES + 1;

  logic [SEQ-1:0] isBase;
  logic [SEQ-1:0] isPfx;
  logic [SEQ-1:0] legal;
  logic [SEQ-1:0] trailVec;

  for (genvar i = 0; i < SEQ; i++) begin : g_ent
    logic prevBase, prev2Base, nextValid, nextLegal, next2Legal;
    logic emitW, illW, nearW, farW;

    assign isBase[i] = cls[i].valid & ~cls[i].isPfx;
    assign isPfx[i]  = cls[i].valid &  cls[i].isPfx;

    if (i >= 1) begin : g_p1
      assign prevBase = isBase[i-1];
    end else begin : g_p1n
      assign prevBase = 1'b0;
    end
    if (i >= 2) begin : g_p2
      assign prev2Base = isBase[i-2];
    end else begin : g_p2n
      assign prev2Base = 1'b0;
    end
    if (i + 1 < SEQ) begin : g_n1
      assign nextValid = cls[i+1].valid;
      assign nextLegal = legal[i+1];
    end else begin : g_n1n
      assign nextValid = 1'b0;
      assign nextLegal = 1'b0;
    end
    if (i + 2 < SEQ) begin : g_n2
      assign next2Legal = legal[i+2] & cls[i+2].pair;
    end else begin : g_n2n
      assign next2Legal = 1'b0;
    end

    assign legal[i] = isPfx[i] & prevBase & (~cls[i].pair | prev2Base);

    // entry 0 is the held instruction: it is never held again
    if (i == 0) begin : g_t0
      assign trailVec[i] = 1'b0;
    end else begin : g_tn
      assign trailVec[i] = isBase[i] & ~nextValid;
    end

    assign illW  = isPfx[i] & ~legal[i];
    assign emitW = (isBase[i] & ~trailVec[i]) | illW;
    assign nearW = isBase[i] & nextLegal;
    assign farW  = isBase[i] & next2Legal;
    assign ctl[i] = {emitW, illW, nearW, farW, trailVec[i]};

    // R1
    ext_sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
      $onehot0({ctl[i].extNear, ctl[i].extFar}));

    if (i >= 1) begin : g_chk
      // R4
      legal_pfx_feeds_base_chk: assert property (@(posedge clk) disable iff (!rstN)
        (isPfx[i] && !ctl[i].illegal) |-> (ctl[i-1].extNear && !ctl[i].emit));
    end
  end

  // R6
  single_trail_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(trailVec));
endmodule

// File: rtl/pfx_comb_dp.sv
module pfx_comb_dp
  import pfx_comb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LANES-1:0]              inValid,
  input  logic [LANES*WORD_W-1:0]       inWord,
  input  entryCtl_t                     ctl [LANES+1],
  output entryCls_t                     cls [LANES+1],
  output logic [LANES:0]                outValid,
  output logic [LANES:0]                outIllegal,
  output logic [(LANES+1)*WORD_W-1:0]   outWord,
  output logic [(LANES+1)*WIDE_W-1:0]   outRd,
  output logic [(LANES+1)*WIDE_W-1:0]   outRs1,
  output logic [(LANES+1)*WIDE_W-1:0]   outRs2
);
  localparam int SEQ   = LANES + 1;
  localparam int OUT   = SEQ;
  localparam int POS_W = $clog2(SEQ + 1);

  logic              holdValid;
  logic [WORD_W-1:0] holdWord;
  logic [SEQ-1:0]    seqValid;
  logic [WORD_W-1:0] seqWord [SEQ];
  logic [PEXT_W-1:0] ext [SEQ];
  slot_t             cand [SEQ];
  slot_t             nxt [OUT];
  slot_t             outQ [OUT];
  logic              holdNext;
  logic [WORD_W-1:0] holdWordNext;

  assign seqValid   = {inValid, holdValid};
  assign seqWord[0] = holdWord;
  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign seqWord[j+1] = inWord[j*WORD_W +: WORD_W];
  end

  for (genvar i = 0; i < SEQ; i++) begin : g_ent
    logic [PEXT_W-1:0] nearBits, farBits;
    if (i + 1 < SEQ) begin : g_n
      assign nearBits = seqWord[i+1][PEXT_W-1:0];
    end else begin : g_nn
      assign nearBits = '0;
    end
    if (i + 2 < SEQ) begin : g_f
      assign farBits = seqWord[i+2][FAR_LSB +: PEXT_W];
    end else begin : g_fn
      assign farBits = '0;
    end

    assign cls[i] = {seqValid[i],
                     seqWord[i][TAG_LSB +: 8] == PFX_TAG,
                     seqWord[i][PAIR_BIT]};
    assign ext[i] = ctl[i].extNear ? nearBits :
                    ctl[i].extFar  ? farBits  : '0;
    assign cand[i] = {1'b1, ctl[i].illegal, seqWord[i],
                      widen(seqWord[i][RD_LSB  +: REG_W], ext[i][0       +: EXT_W]),
                      widen(seqWord[i][RS1_LSB +: REG_W], ext[i][EXT_W   +: EXT_W]),
                      widen(seqWord[i][RS2_LSB +: REG_W], ext[i][2*EXT_W +: EXT_W])};
  end

  // compaction in stream order, plus capture of the trailing base
  always_comb begin
    logic [POS_W-1:0] pos;
    pos          = '0;
    holdNext     = 1'b0;
    holdWordNext = holdWord;
    for (int k = 0; k < OUT; k++) nxt[k] = '0;
    for (int i = 0; i < SEQ; i++) begin
      if (ctl[i].emit) begin
        nxt[pos] = cand[i];
        pos      = pos + 1'b1;
      end
      if (ctl[i].trail) begin
        holdNext     = 1'b1;
        holdWordNext = seqWord[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdValid <= 1'b0;
      holdWord  <= '0;
      for (int k = 0; k < OUT; k++) outQ[k] <= '0;
    end else begin
      holdValid <= holdNext;
      holdWord  <= holdWordNext;
      for (int k = 0; k < OUT; k++) outQ[k] <= nxt[k];
    end
  end

  for (genvar k = 0; k < OUT; k++) begin : g_out
    assign outValid[k]                     = outQ[k].valid;
    assign outIllegal[k]                   = outQ[k].illegal;
    assign outWord[k*WORD_W +: WORD_W]     = outQ[k].word;
    assign outRd[k*WIDE_W +: WIDE_W]       = outQ[k].rd;
    assign outRs1[k*WIDE_W +: WIDE_W]      = outQ[k].rs1;
    assign outRs2[k*WIDE_W +: WIDE_W]      = outQ[k].rs2;
  end

  // R8
  out_compact_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((outValid + 1'b1) & outValid) == '0);
  // R5
  illegal_has_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outIllegal & ~outValid) == '0);
  // R10
  base_limit_chk: assert property (@(posedge clk) disable iff (!rstN)
    $countones(outValid & ~outIllegal) <= LANES);
  // R7
  hold_drains_chk: assert property (@(posedge clk) disable iff (!rstN)
    holdValid |=> (outValid[0] && !outIllegal[0]));
endmodule

// File: rtl/pfx_combiner.sv
module pfx_combiner
  import pfx_comb_pkg::*;
#(
  parameter int LANES = 4
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [LANES-1:0]              inValid,
  input  logic [LANES*WORD_W-1:0]       inWord,
  output logic [LANES:0]                outValid,
  output logic [LANES:0]                outIllegal,
  output logic [(LANES+1)*WORD_W-1:0]   outWord,
  output logic [(LANES+1)*WIDE_W-1:0]   outRd,
  output logic [(LANES+1)*WIDE_W-1:0]   outRs1,
  output logic [(LANES+1)*WIDE_W-1:0]   outRs2
);
  entryCls_t cls [LANES+1];
  entryCtl_t ctl [LANES+1];

  pfx_comb_ctl #(.LANES(LANES)) u_ctl (
    .clk  (clk),
    .rstN (rstN),
    .cls  (cls),
    .ctl  (ctl)
  );

  pfx_comb_dp #(.LANES(LANES)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inWord     (inWord),
    .ctl        (ctl),
    .cls        (cls),
    .outValid   (outValid),
    .outIllegal (outIllegal),
    .outWord    (outWord),
    .outRd      (outRd),
    .outRs1     (outRs1),
    .outRs2     (outRs2)
  );
endmodule

// File: tb/pfx_combiner_tb.sv
`timescale 1ns/1ps
module pfx_combiner_tb;
  logic         clk = 1'b0;
  logic         rstN;
  logic [3:0]   inValid;
  logic [127:0] inWord;
  logic [4:0]   outValid, outIllegal;
  logic [159:0] outWord;
  logic [39:0]  outRd, outRs1, outRs2;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  pfx_combiner #(.LANES(4)) u_dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inWord(inWord),
    .outValid(outValid), .outIllegal(outIllegal), .outWord(outWord),
    .outRd(outRd), .outRs1(outRs1), .outRs2(outRs2)
  );

  function automatic logic [31:0] bw(input int n);
    logic [4:0] a, b, c;
    a = 5'(n); b = 5'(n + 7); c = 5'(n + 13);
    return {2'b00, a, 6'h15, b, 9'h0A5, c};
  endfunction

  function automatic logic [31:0] pw(input logic pair, input logic [8:0] nearE,
                                     input logic [8:0] farE);
    return {8'hF7, pair, 5'b00000, farE, nearE};
  endfunction

  task automatic apply(input logic [3:0] v, input logic [31:0] w0, input logic [31:0] w1,
                       input logic [31:0] w2, input logic [31:0] w3);
    inValid = v;
    inWord  = {w3, w2, w1, w0};
    @(negedge clk);
  endtask

  task automatic idle();
    apply(4'b0000, 32'h0, 32'h0, 32'h0, 32'h0);
  endtask

  task automatic chkCount(input int n, input string req);
    logic [4:0] exp;
    exp = 5'((1 << n) - 1);
    nChecks++;
    if (outValid !== exp) begin
      nFails++;
      $display("FAIL %s outValid got %b exp %b", req, outValid, exp);
    end
  endtask

  task automatic chkSlot(input int k, input logic [31:0] w, input logic [8:0] e,
                         input string req);
    logic [57:0] act, exp;
    act = {outValid[k], outIllegal[k], outWord[k*32 +: 32], outRd[k*8 +: 8],
           outRs1[k*8 +: 8], outRs2[k*8 +: 8]};
    exp = {1'b1, 1'b0, w, {e[2:0], w[29:25]}, {e[5:3], w[18:14]}, {e[8:6], w[4:0]}};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s slot %0d got %h exp %h", req, k, act, exp);
    end
  endtask

  task automatic chkIll(input int k, input logic [31:0] w, input string req);
    logic [33:0] act, exp;
    act = {outValid[k], outIllegal[k], outWord[k*32 +: 32]};
    exp = {1'b1, 1'b1, w};
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s illegal slot %0d got %h exp %h", req, k, act, exp);
    end
  endtask

  // R3 R8 R9 R7: bases only, trailing one drains on an empty cycle
  task automatic testBasesOnly();
    apply(4'b1111, bw(1), bw(2), bw(3), bw(4));
    chkCount(3, "R9");
    chkSlot(0, bw(1), 9'h0, "R3");
    chkSlot(1, bw(2), 9'h0, "R8");
    chkSlot(2, bw(3), 9'h0, "R8");
    idle();
    chkCount(1, "R7");
    chkSlot(0, bw(4), 9'h0, "R7");
    idle();
    chkCount(0, "R6");
  endtask

  // R2 R4: single prefix in the middle of a group
  task automatic testMidPrefix();
    apply(4'b1111, bw(5), pw(1'b0, 9'h1AB, 9'h0), bw(6), bw(7));
    chkCount(2, "R4");
    chkSlot(0, bw(5), 9'h1AB, "R2");
    chkSlot(1, bw(6), 9'h0, "R3");
    idle();
    chkSlot(0, bw(7), 9'h0, "R7");
    idle();
  endtask

  // R1: pair prefix, near to the nearest base, far to the one before
  task automatic testPairInGroup();
    apply(4'b1111, bw(8), bw(9), pw(1'b1, 9'h0C5, 9'h13A), bw(10));
    chkCount(2, "R1");
    chkSlot(0, bw(8), 9'h13A, "R1");
    chkSlot(1, bw(9), 9'h0C5, "R1");
    idle();
    idle();
  endtask

  // R4 R6: group ending in a prefix leaves nothing held
  task automatic testEndPrefix();
    apply(4'b1111, bw(11), bw(12), bw(13), pw(1'b0, 9'h07E, 9'h0));
    chkCount(3, "R4");
    chkSlot(2, bw(13), 9'h07E, "R2");
    idle();
    chkCount(0, "R6");
  endtask

  // R6: held base merged with a single prefix in the next group
  task automatic testCrossSingle();
    apply(4'b0011, bw(14), bw(15), 32'h0, 32'h0);
    chkCount(1, "R6");
    chkSlot(0, bw(14), 9'h0, "R6");
    apply(4'b0111, pw(1'b0, 9'h155, 9'h0), bw(16), bw(17), 32'h0);
    chkCount(2, "R6");
    chkSlot(0, bw(15), 9'h155, "R6");
    chkSlot(1, bw(16), 9'h0, "R8");
    idle();
    chkSlot(0, bw(17), 9'h0, "R7");
    idle();
  endtask

  // R6: held base is the far target of a pair prefix at lane 1
  task automatic testCrossPair();
    apply(4'b0011, bw(18), bw(19), 32'h0, 32'h0);
    chkSlot(0, bw(18), 9'h0, "R6");
    apply(4'b0011, bw(20), pw(1'b1, 9'h0F0, 9'h10F), 32'h0, 32'h0);
    chkCount(2, "R6");
    chkSlot(0, bw(19), 9'h10F, "R6");
    chkSlot(1, bw(20), 9'h0F0, "R6");
    idle();
    chkCount(0, "R6");
  endtask

  // R5: orphan, half-matched pair and back-to-back prefixes
  task automatic testIllegal();
    apply(4'b0001, pw(1'b0, 9'h011, 9'h0), 32'h0, 32'h0, 32'h0);
    chkCount(1, "R5");
    chkIll(0, pw(1'b0, 9'h011, 9'h0), "R5");
    apply(4'b0011, bw(21), pw(1'b1, 9'h022, 9'h033), 32'h0, 32'h0);
    chkCount(2, "R5");
    chkSlot(0, bw(21), 9'h0, "R5");
    chkIll(1, pw(1'b1, 9'h022, 9'h033), "R5");
    apply(4'b1111, bw(22), pw(1'b0, 9'h0AA, 9'h0), pw(1'b0, 9'h0BB, 9'h0), bw(23));
    chkCount(2, "R5");
    chkSlot(0, bw(22), 9'h0AA, "R5");
    chkIll(1, pw(1'b0, 9'h0BB, 9'h0), "R5");
    idle();
    chkSlot(0, bw(23), 9'h0, "R7");
    idle();
  endtask

  // R8 R10: held base plus four unmatched prefixes fills all five slots
  task automatic testFiveSlots();
    apply(4'b0001, bw(24), 32'h0, 32'h0, 32'h0);
    chkCount(0, "R6");
    apply(4'b1111, pw(1'b1, 9'h001, 9'h002), pw(1'b1, 9'h003, 9'h004),
          pw(1'b1, 9'h005, 9'h006), pw(1'b1, 9'h007, 9'h008));
    chkCount(5, "R8");
    chkSlot(0, bw(24), 9'h0, "R10");
    chkIll(1, pw(1'b1, 9'h001, 9'h002), "R5");
    chkIll(4, pw(1'b1, 9'h007, 9'h008), "R8");
    idle();
    chkCount(0, "R10");
  endtask

  // R10: held base plus three new bases fill four base slots
  task automatic testFourBases();
    apply(4'b1111, bw(25), bw(26), bw(27), bw(28));
    chkCount(3, "R10");
    apply(4'b1111, bw(29), bw(30), bw(31), pw(1'b0, 9'h1C3, 9'h0));
    chkCount(4, "R10");
    chkSlot(0, bw(28), 9'h0, "R10");
    chkSlot(3, bw(31), 9'h1C3, "R10");
    idle();
    chkCount(0, "R10");
  endtask

  initial begin
    rstN    = 1'b0;
    inValid = '0;
    inWord  = '0;
    repeat (3) @(negedge clk);
    chkCount(0, "R9");
    rstN = 1'b1;
    @(negedge clk);
    chkCount(0, "R9");
    testBasesOnly();
    testMidPrefix();
    testPairInGroup();
    testEndPrefix();
    testCrossSingle();
    testCrossPair();
    testIllegal();
    testFiveSlots();
    testFourBases();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      done = 1'b1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
      $finish;
    end
  end
endmodule